// File: doc/BRIEF.md
# Display pipeline flush and start sequencer

This block is one control path of a display overlay processor. Software-visible activity reaches it as four kinds of request. A commit carries a 32-bit mask of blocks whose double-buffered settings are ready to move into their active copies. A blend or cursor update marks that the control registers themselves will need flushing. An interface configuration names the output type, its number, the DSI mode and the mixer that feeds it. An encoder enable level reports whether the output side can stream.

For every commit, the block forms the flush word that goes to the flush register. It may add the control-register bit. It may substitute the mixer bit for a cursor bit that the hardware lacks. It then clears every bit that the hardware does not implement. Pipelines that only move on an explicit kick (writeback, and DSI in command mode) get a one-cycle start pulse. That pulse fires once every block the pipeline depends on has been flushed since the previous start.

Both strobes are registered. A request sampled on clock edge N shows its flush write and start pulse in the cycle that follows edge N.

Top module: `flush_start_seq`

## Requirements
- R1: After reset, `flush_wr`, `start_wr` and `flush_data` are 0, and no start is pending: the interface type is 0, the readiness mask, the pending trigger and the encoder flag are cleared, and the mixer index is 0.
- R2: A commit with mask M gives `flush_wr`=1 in the next cycle with `flush_data` = (M plus any bits added by R4 and R5) AND `HW_MASK`. When that value is zero, no flush write occurs.
- R3: Flush bit encodings are as follows.
  - Mixer 0, 1, 2 and 5 map to bits 6, 7, 8 and 20; any other mixer index gives no bit.
  - Cursor 0 maps to bit 22 and cursor 1 to bit 23.
  - The control registers map to bit 17.
  - A writeback encoder maps to bit 16.
  - Timing interfaces 0, 1, 2 and 3 map to bits 31, 30, 29 and 28; any other number gives no bit.
  - Interface type codes are 0 for a video timing output, 1 for DSI and 2 for writeback.
- R4: A blend update sets the pending trigger to that mixer's bit, and a cursor update sets it to that cursor's bit; a cursor update wins when both arrive together. A commit whose mask overlaps the pending trigger adds bit 17 to the flush word and clears the trigger.
- R5: When the flush word holds bit 22 (after R4) and `HW_MASK` bit 22 is 0, the bit of the configured mixer is added before the hardware mask is applied.
- R6: An interface configuration loads the readiness mask with the mixer bit OR the encoder bit. Each commit clears the bits of its raw mask from the readiness mask.
- R7: A start pulse requires all three of the following: the encoder enabled, an empty readiness mask, and an interface that is writeback, or DSI with `cfg_cmd_mode`=1. A video timing output or DSI in video mode never starts.
- R8: The start condition is tested after each commit and again on every change of `enc_en`. A rising enable with an already empty readiness mask starts the pipeline without any commit.
- R9: After a start, the readiness mask is refilled with the mixer bit. For writeback only, the encoder bit is added as well.
- R10: When a commit and an encoder change arrive in the same cycle, the commit is evaluated first against the previous encoder state. The encoder change is then evaluated against the mask left by the commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Load interface configuration |
| cfg_intf_type | input | 2 | 0 video timing, 1 DSI, 2 writeback |
| cfg_intf_num | input | 3 | Timing interface number |
| cfg_cmd_mode | input | 1 | DSI command mode when 1 |
| cfg_mixer | input | 3 | Mixer index feeding the pipeline |
| blend_valid | input | 1 | Blend update notification |
| blend_mixer | input | 3 | Mixer of the blend update |
| cursor_valid | input | 1 | Cursor update notification |
| cursor_id | input | 1 | Cursor of the update |
| commit_valid | input | 1 | Commit request |
| commit_mask | input | 32 | Requested flush bits |
| enc_en | input | 1 | Encoder enable level |
| flush_wr | output | 1 | Flush register write strobe |
| flush_data | output | 32 | Flush register write data |
| start_wr | output | 1 | Start register write strobe (data 1) |

## Verification
The bench builds the block with its default parameters. The hardware-present mask 0x003fffff leaves out both cursor bits and all four timing-encoder bits. That makes cursor-to-mixer substitution observable, and it produces commits whose whole request is filtered away even though the readiness mask still tracks those bits. The default mixer bit positions place mixer 5 at bit 20, inside the mask, so the substituted bit is visible in the flush word. An unknown mixer index combined with an unknown interface number gives an empty readiness mask, which exercises starts with no flush in between.

// File: rtl/flush_start_seq.sv
module flush_start_seq #(
  parameter logic [31:0] HW_MASK  = 32'h003f_ffff,
  parameter int          CTL_BIT  = 17,
  parameter int          MIX0_BIT = 6,
  parameter int          MIX1_BIT = 7,
  parameter int          MIX2_BIT = 8,
  parameter int          MIX5_BIT = 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_valid,
  input  logic [1:0]  cfg_intf_type,
  input  logic [2:0]  cfg_intf_num,
  input  logic        cfg_cmd_mode,
  input  logic [2:0]  cfg_mixer,
  input  logic        blend_valid,
  input  logic [2:0]  blend_mixer,
  input  logic        cursor_valid,
  input  logic        cursor_id,
  input  logic        commit_valid,
  input  logic [31:0] commit_mask,
  input  logic        enc_en,
  output logic        flush_wr,
  output logic [31:0] flush_data,
  output logic        start_wr
);
  localparam logic [31:0] CUR0_F = 32'h0040_0000;
  localparam logic [31:0] CUR1_F = 32'h0080_0000;
  localparam logic [31:0] WB_F   = 32'h0001_0000;
  localparam logic [31:0] CTL_F  = 32'd1 << CTL_BIT;
  localparam logic [1:0]  TY_DSI = 2'd1;
  localparam logic [1:0]  TY_WB  = 2'd2;

  function automatic logic [31:0] mix_bit(input logic [2:0] m);
    case (m)
      3'd0:    return 32'd1 << MIX0_BIT;
      3'd1:    return 32'd1 << MIX1_BIT;
      3'd2:    return 32'd1 << MIX2_BIT;
      3'd5:    return 32'd1 << MIX5_BIT;
      default: return '0;
    endcase
  endfunction

  function automatic logic [31:0] enc_bit(input logic [1:0] t, input logic [2:0] n);
    if (t == TY_WB) return WB_F;
    case (n)
      3'd0:    return 32'h8000_0000;
      3'd1:    return 32'h4000_0000;
      3'd2:    return 32'h2000_0000;
      3'd3:    return 32'h1000_0000;
      default: return '0;
    endcase
  endfunction

  logic [1:0]  type_q;
  logic        cmd_q, enc_q;
  logic [2:0]  mix_q;
  logic [31:0] ready_q, pend_q;

  logic        start_kind, hit, start_a, start_b;
  logic [31:0] refill, with_ctl, subst, word, ready_c, ready_a, ready_n, pend_n;

  assign start_kind = (type_q == TY_WB) || (type_q == TY_DSI && cmd_q);
  assign refill     = mix_bit(mix_q) | ((type_q == TY_WB) ? WB_F : '0);
  assign hit        = |(pend_q & commit_mask);
  assign with_ctl   = commit_mask | (hit ? CTL_F : '0);
  assign subst      = ((with_ctl & CUR0_F) != 0 && (HW_MASK & CUR0_F) == 0) ? mix_bit(mix_q) : '0;
  assign word       = (with_ctl | subst) & HW_MASK;

  assign ready_c = commit_valid ? (ready_q & ~commit_mask) : ready_q;
  assign start_a = commit_valid && enc_q && ready_c == 0 && start_kind;
  assign ready_a = start_a ? refill : ready_c;
  assign start_b = (enc_en != enc_q) && enc_en && ready_a == 0 && start_kind;
  assign ready_n = cfg_valid ? (mix_bit(cfg_mixer) | enc_bit(cfg_intf_type, cfg_intf_num))
                             : (start_b ? refill : ready_a);

  always_comb begin
    pend_n = pend_q;
    if (commit_valid && hit) pend_n = '0;
    if (blend_valid)  pend_n = mix_bit(blend_mixer);
    if (cursor_valid) pend_n = cursor_id ? CUR1_F : CUR0_F;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      type_q <= '0; cmd_q <= 1'b0; mix_q <= '0; enc_q <= 1'b0;
      ready_q <= '0; pend_q <= '0;
      flush_wr <= 1'b0; flush_data <= '0; start_wr <= 1'b0;
    end else begin
      if (cfg_valid) begin
        type_q <= cfg_intf_type; cmd_q <= cfg_cmd_mode; mix_q <= cfg_mixer;
      end
      enc_q      <= enc_en;
      ready_q    <= ready_n;
      pend_q     <= pend_n;
      flush_wr   <= commit_valid && word != 0;
      flush_data <= (commit_valid && word != 0) ? word : '0;
      start_wr   <= start_a || start_b;
    end
  end

  assert_flush_in_hw_R2: assert property (@(posedge clk) disable iff (!rst_n)
    flush_wr |-> (flush_data & ~HW_MASK) == 0);
  assert_flush_covers_request_R2: assert property (@(posedge clk) disable iff (!rst_n)
    flush_wr |-> $past(commit_valid) && (($past(commit_mask) & HW_MASK) & ~flush_data) == 0);
  assert_ctl_bit_needs_trigger_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_wr && (flush_data & CTL_F) != 0 && (HW_MASK & CTL_F) != 0 &&
     ($past(commit_mask) & CTL_F) == 0) |-> ($past(pend_q) & $past(commit_mask)) != 0);
  assert_start_kind_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |-> $past(type_q) == TY_WB || ($past(type_q) == TY_DSI && $past(cmd_q)));
  assert_start_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_wr |-> $past(commit_valid) || ($past(enc_en) && !$past(enc_q)));
endmodule

// File: tb/flush_start_seq_test.sv
module flush_start_seq_test;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic cfg_valid = 0, cfg_cmd_mode = 0, blend_valid = 0, cursor_valid = 0, cursor_id = 0;
  logic commit_valid = 0, enc_en = 0;
  logic [1:0] cfg_intf_type = 0;
  logic [2:0] cfg_intf_num = 0, cfg_mixer = 0, blend_mixer = 0;
  logic [31:0] commit_mask = 0;
  logic flush_wr, start_wr;
  logic [31:0] flush_data;
  logic fw_s, sw_s;
  logic [31:0] fd_s;
  int checks = 0, errors = 0;

  always #(PERIOD/2) clk = ~clk;

  flush_start_seq uut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic sample();
    @(posedge clk); #1;
    fw_s = flush_wr; fd_s = flush_data; sw_s = start_wr;
    cfg_valid = 0; blend_valid = 0; cursor_valid = 0; commit_valid = 0; commit_mask = 0;
  endtask

  task automatic do_cfg(input logic [1:0] t, input logic [2:0] n, input logic c, input logic [2:0] m);
    @(negedge clk);
    cfg_valid = 1; cfg_intf_type = t; cfg_intf_num = n; cfg_cmd_mode = c; cfg_mixer = m;
    sample();
  endtask

  task automatic do_commit(input logic [31:0] m);
    @(negedge clk); commit_valid = 1; commit_mask = m; sample();
  endtask

  task automatic do_enc(input logic e);
    @(negedge clk); enc_en = e; sample();
  endtask

  task automatic do_blend(input logic [2:0] m);
    @(negedge clk); blend_valid = 1; blend_mixer = m; sample();
  endtask

  task automatic do_cursor(input logic id);
    @(negedge clk); cursor_valid = 1; cursor_id = id; sample();
  endtask

  task automatic expect_out(input string req, input logic fw, input logic [31:0] fd, input logic sw);
    check({req, " flush_wr"}, 32'(fw_s), 32'(fw));
    check({req, " flush_data"}, fd_s, fw ? fd : 32'h0);
    check({req, " start_wr"}, 32'(sw_s), 32'(sw));
  endtask

  task automatic t_reset();
    #1; fw_s = flush_wr; fd_s = flush_data; sw_s = start_wr;
    expect_out("R1 reset", 0, 0, 0);
    do_enc(1);
    expect_out("R1 no start after reset", 0, 0, 0);
    do_commit(32'h0);
    expect_out("R2 empty commit", 0, 0, 0);
  endtask

  task automatic t_filter();
    do_commit(32'hffff_ffff);
    expect_out("R2 all bits", 1, 32'h003f_ffff, 0);
    do_commit(32'h8000_0040);
    expect_out("R2 timing bit dropped", 1, 32'h0000_0040, 0);
    do_commit(32'hf000_0000);
    expect_out("R2 nothing left", 0, 0, 0);
  endtask

  task automatic t_cursor_sub();
    do_cfg(2'd0, 3'd0, 0, 3'd5);
    do_commit(32'h0040_0000);
    expect_out("R5 cursor0 to mixer5", 1, 32'h0010_0000, 0);
    do_commit(32'h0080_0000);
    expect_out("R5 cursor1 no substitute", 0, 0, 0);
  endtask

  task automatic t_trigger();
    do_blend(3'd1);
    do_commit(32'h0000_0001);
    expect_out("R4 no overlap", 1, 32'h0000_0001, 0);
    do_commit(32'h0000_0080);
    expect_out("R4 overlap adds ctl", 1, 32'h0002_0080, 0);
    do_commit(32'h0000_0080);
    expect_out("R4 trigger cleared", 1, 32'h0000_0080, 0);
    do_cursor(1'b0);
    do_commit(32'h0040_0000);
    expect_out("R4 cursor trigger with R5", 1, 32'h0012_0000, 0);
  endtask

  task automatic t_writeback();
    do_enc(0);
    do_cfg(2'd2, 3'd7, 0, 3'd2);
    do_enc(1);
    expect_out("R8 enable with mask pending", 0, 0, 0);
    do_commit(32'h0000_0100);
    expect_out("R6 mixer cleared only", 1, 32'h0000_0100, 0);
    do_commit(32'h0001_0000);
    expect_out("R7 writeback start", 1, 32'h0001_0000, 1);
    do_commit(32'h0000_0100);
    expect_out("R9 writeback refill has encoder", 1, 32'h0000_0100, 0);
    do_commit(32'h0001_0000);
    expect_out("R9 writeback second start", 1, 32'h0001_0000, 1);
  endtask

  task automatic t_dsi();
    do_cfg(2'd1, 3'd0, 1, 3'd0);
    do_commit(32'h8000_0040);
    expect_out("R7 dsi command start", 1, 32'h0000_0040, 1);
    do_commit(32'h0000_0040);
    expect_out("R9 dsi refill mixer only", 1, 32'h0000_0040, 1);
    do_cfg(2'd1, 3'd0, 0, 3'd0);
    do_commit(32'h8000_0040);
    expect_out("R7 dsi video no start", 1, 32'h0000_0040, 0);
    do_cfg(2'd0, 3'd0, 0, 3'd0);
    do_commit(32'h8000_0040);
    expect_out("R7 video timing no start", 1, 32'h0000_0040, 0);
  endtask

  task automatic t_enc_event();
    do_cfg(2'd1, 3'd1, 1, 3'd1);
    do_enc(0);
    expect_out("R8 falling no start", 0, 0, 0);
    do_commit(32'h4000_0080);
    expect_out("R7 encoder off no start", 1, 32'h0000_0080, 0);
    do_enc(1);
    expect_out("R8 rising starts", 0, 0, 1);
  endtask

  task automatic t_same_cycle();
    do_cfg(2'd1, 3'd2, 1, 3'd2);
    do_commit(32'h2000_0000);
    expect_out("R6 encoder bit only", 0, 0, 0);
    @(negedge clk);
    commit_valid = 1; commit_mask = 32'h0000_0100; enc_en = 0;
    sample();
    expect_out("R10 commit before disable", 1, 32'h0000_0100, 1);
  endtask

  task automatic t_unknown();
    do_cfg(2'd1, 3'd5, 1, 3'd3);
    do_enc(1);
    expect_out("R3 unknown mixer and number give empty mask", 0, 0, 1);
    do_commit(32'h0);
    expect_out("R9 empty refill restarts", 0, 0, 1);
  endtask

  initial begin
    #(PERIOD * 20000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_filter();
    t_cursor_sub();
    t_trigger();
    t_writeback();
    t_dsi();
    t_enc_event();
    t_same_cycle();
    t_unknown();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule